// File: doc/BRIEF.md
# Multiplexed ADC Sequencing Controller

This block sequences one analog-to-digital converter that sits behind an input multiplexer of up to ten channels. Eight channels are differential inputs. Channel 8 carries the +10 V reference and channel 9 carries the 0 V reference. The host configures and starts a conversion with a single 16-bit control word. That word holds four things: a start bit, the multiplexer select, a per-channel enable mask and a flag that adds a settling wait before sampling.

Once a start is accepted, the controller takes these steps:
- It optionally waits out a fixed settling interval.
- It gives the external converter a one-cycle start pulse.
- It waits for the converter's busy line to rise and fall.
- It captures the 16-bit result.
- It raises a conversion-done status bit, which can drive an interrupt line.

The result is kept in offset-binary form. Software gets the signed value by inverting the top bit. The host clears the done bit by writing 1 to it.

The host bus is a plain single-cycle write port plus a combinational read port. There are four word addresses:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Interrupt enable |
| 2 | Interrupt status |
| 3 | Result (read-only) |

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control word layout: bit 0 is start, bits 4:1 are the channel select, bits 14:5 are the enable mask with channel n at bit 5+n, and bit 15 is the settle flag. A write at address 0 stores the word. Reading address 0 returns the stored word with bit 0 read as 0. Output `mux_sel` always shows the stored select field.
- R2: A start is accepted from idle when it names an enabled channel and the settle flag is clear. The accepting write edge is followed by exactly one cycle of `cnv_start`. The done status reads 1 exactly 3+L clock edges after the accepting edge, where L is the number of cycles the converter holds busy high.
- R3: With the settle flag set, the sequencer spends exactly 64 cycles settling before `cnv_start` is pulsed. `cnv_start` stays low during that wait, so the done status appears 64 edges later than in R2.
- R4: The result register (address 3) holds the 16-bit converter word that was present when busy fell, unchanged. It keeps that value until the next completed conversion.
- R5: Bit 2 of the status register (address 2) is set on completion. Writing 1 to bit 2 clears it. Writing 0 to bit 2 leaves it unchanged.
- R6: Bit 2 of the interrupt enable register (address 1) gates the done status. `irq` is high exactly when both the status bit and the enable bit are 1.
- R7: A start whose select names a channel of 10 or above, or a channel whose enable bit is 0, is ignored. A control write with bit 0 clear also starts nothing. In each case no `cnv_start` is produced and the done status stays 0.
- R8: While a conversion is in progress (settling, converting or completing), any write to the control register is ignored entirely. The stored word, `mux_sel` and the running conversion are unaffected.
- R9: After reset, all four registers read 0, and `irq` and `cnv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| host_addr | input | 2 | Register word address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Combinational read data for `host_addr` |
| cnv_start | output | 1 | One-cycle start pulse to the converter |
| mux_sel | output | 4 | Input multiplexer select |
| cnv_busy | input | 1 | Converter busy; its falling edge marks valid data |
| cnv_data | input | 16 | Converter result, offset binary |
| irq | output | 1 | Conversion-done interrupt |

## Verification
Every result of this block has a fixed due cycle, counted from the clock edge that accepts the write:
- The start pulse is due in the cycle right after that edge.
- The done bit is due 3+L edges later, or 67+L edges later with the settle flag set.
- The captured result is due together with the done bit.
- A status clear or an enable change shows one edge after its write.

The bench counts edges from the accepting write and compares the count with the value computed from these rules. It reads the status on each falling clock edge, so the exact cycle of arrival is what gets checked, not merely the arrival itself. For ignored starts, the bench waits longer than the longest settled conversion, then checks that the status is still 0 and that no start pulse was counted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Control word field positions (decoded by the sequencer and the host)
  localparam int CW_W       = 16;
  localparam int CW_START   = 0;
  localparam int CW_SEL_LSB = 1;
  localparam int CW_SEL_W   = 4;
  localparam int CW_EN_LSB  = 5;
  localparam int CW_SETTLE  = 15;

  // Conversion-done bit inside the enable and status registers
  localparam int IRQ_DONE_BIT = 2;

  // Register word addresses
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IRQST  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_SETTLE  = 2'd1,
    SEQ_CONVERT = 2'd2,
    SEQ_DONE    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/adc_seq_settle_timer.sv
module adc_seq_settle_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | (run & ~zero);

  always_comb begin
    if (load) cnt_d = RELOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_settle,
  input  logic       tmr_zero,
  input  logic       cnv_busy,
  output seq_state_e state,
  output logic       seq_idle,
  output logic       tmr_load,
  output logic       tmr_run,
  output logic       cnv_start,
  output logic       result_load,
  output logic       done_set
);
  seq_state_e state_q, state_d;
  logic       seen_q, seen_d;
  logic       pulse_q, pulse_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (go) state_d = go_settle ? SEQ_SETTLE : SEQ_CONVERT;
      end
      SEQ_SETTLE: begin
        if (tmr_zero) state_d = SEQ_CONVERT;
      end
      SEQ_CONVERT: begin
        if (seen_q && !cnv_busy) state_d = SEQ_DONE;
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  // The converter must raise busy before its fall counts as completion
  always_comb begin
    if (state_q == SEQ_CONVERT) seen_d = seen_q | cnv_busy;
    else                        seen_d = 1'b0;
  end

  assign pulse_d = (state_d == SEQ_CONVERT) && (state_q != SEQ_CONVERT);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assign state       = state_q;
  assign seq_idle    = (state_q == SEQ_IDLE);
  assign tmr_load    = seq_idle & go & go_settle;
  assign tmr_run     = (state_q == SEQ_SETTLE);
  assign cnv_start   = pulse_q;
  assign result_load = (state_q == SEQ_CONVERT) & seen_q & ~cnv_busy;
  assign done_set    = (state_q == SEQ_DONE);

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [CW_W-1:0]    host_wdata,
  output logic [CW_W-1:0]    host_rdata,
  input  logic               seq_idle,
  input  logic               done_set,
  input  logic               result_load,
  input  logic [DATA_W-1:0]  result_in,
  output logic               start_cmd,
  output logic               settle_cmd,
  output logic [CW_SEL_W-1:0] sel_cmd,
  output logic [NUM_CH-1:0]  mask_cmd,
  output logic [CW_W-1:0]    ctrl_word,
  output logic               irq_en,
  output logic               done_stat,
  output logic [DATA_W-1:0]  result_word
);
  logic [CW_W-1:0]   ctrl_q;
  logic              ie_q;
  logic              st_q, st_d;
  logic [DATA_W-1:0] res_q;

  logic ctrl_en, ie_en, st_en;
  logic wr_ctrl, wr_ie, wr_st;

  assign wr_ctrl = host_wr & (host_addr == ADDR_CTRL);
  assign wr_ie   = host_wr & (host_addr == ADDR_IRQEN);
  assign wr_st   = host_wr & (host_addr == ADDR_IRQST);

  // Control writes are accepted only while the sequencer is idle
  assign ctrl_en = wr_ctrl & seq_idle;
  assign ie_en   = wr_ie;

  // Completion wins over a simultaneous clear
  assign st_d  = done_set | (st_q & ~(wr_st & host_wdata[IRQ_DONE_BIT]));
  assign st_en = done_set | wr_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= 1'b0;
      st_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      if (ctrl_en)     ctrl_q <= {host_wdata[CW_W-1:1], 1'b0};
      if (ie_en)       ie_q   <= host_wdata[IRQ_DONE_BIT];
      if (st_en)       st_q   <= st_d;
      if (result_load) res_q  <= result_in;
    end
  end

  // Command decode of the word being written this cycle
  assign start_cmd  = ctrl_en & host_wdata[CW_START];
  assign settle_cmd = host_wdata[CW_SETTLE];
  assign sel_cmd    = host_wdata[CW_SEL_LSB +: CW_SEL_W];
  assign mask_cmd   = host_wdata[CW_EN_LSB +: NUM_CH];

  // Read mux
  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      ADDR_CTRL:   host_rdata = ctrl_q;
      ADDR_IRQEN:  host_rdata[IRQ_DONE_BIT] = ie_q;
      ADDR_IRQST:  host_rdata[IRQ_DONE_BIT] = st_q;
      ADDR_RESULT: host_rdata[DATA_W-1:0] = res_q;
      default:     host_rdata = '0;
    endcase
  end

  assign ctrl_word   = ctrl_q;
  assign irq_en      = ie_q;
  assign done_stat   = st_q;
  assign result_word = res_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int NUM_CH        = 10,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              cnv_start,
  output logic [3:0]        mux_sel,
  input  logic              cnv_busy,
  input  logic [DATA_W-1:0] cnv_data,
  output logic              irq
);
  seq_state_e            seq_state;
  logic                  seq_idle;
  logic                  tmr_load, tmr_run, tmr_zero;
  logic                  res_load, done_set;
  logic                  start_cmd, settle_cmd;
  logic [CW_SEL_W-1:0]   sel_cmd;
  logic [NUM_CH-1:0]     mask_cmd;
  logic [CW_W-1:0]       ctrl_word;
  logic                  irq_en, done_stat;
  logic [DATA_W-1:0]     result_word;
  logic [NUM_CH-1:0]     ch_hit;
  logic                  go;

  // One decoder slice per channel: selected and enabled
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
    assign ch_hit[ch] = (sel_cmd == CW_SEL_W'(ch)) & mask_cmd[ch];
  end

  assign go = start_cmd & (|ch_hit);

  adc_seq_regs #(
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .seq_idle    (seq_idle),
    .done_set    (done_set),
    .result_load (res_load),
    .result_in   (cnv_data),
    .start_cmd   (start_cmd),
    .settle_cmd  (settle_cmd),
    .sel_cmd     (sel_cmd),
    .mask_cmd    (mask_cmd),
    .ctrl_word   (ctrl_word),
    .irq_en      (irq_en),
    .done_stat   (done_stat),
    .result_word (result_word)
  );

  adc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .go_settle   (settle_cmd),
    .tmr_zero    (tmr_zero),
    .cnv_busy    (cnv_busy),
    .state       (seq_state),
    .seq_idle    (seq_idle),
    .tmr_load    (tmr_load),
    .tmr_run     (tmr_run),
    .cnv_start   (cnv_start),
    .result_load (res_load),
    .done_set    (done_set)
  );

  adc_seq_settle_timer #(
    .CYCLES (SETTLE_CYCLES)
  ) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (tmr_run),
    .zero  (tmr_zero)
  );

  assign mux_sel = ctrl_word[CW_SEL_LSB +: CW_SEL_W];
  assign irq     = done_stat & irq_en;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
  import adc_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int SETTLE_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [1:0]        host_addr,
  input logic              clr_bit,
  input logic              cnv_start,
  input logic              irq,
  input seq_state_e        state,
  input logic              stat,
  input logic              ie,
  input logic [15:0]       ctrl,
  input logic [DATA_W-1:0] result,
  input logic              result_load
);
  logic [15:0] settle_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  settle_len <= '0;
    else if (state == SEQ_SETTLE) settle_len <= settle_len + 1'b1;
    else                         settle_len <= '0;
  end

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  assert_start_in_convert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> (state == SEQ_CONVERT));

  assert_settle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_SETTLE) |-> !cnv_start);

  assert_settle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_SETTLE) |-> (settle_len < 16'(SETTLE_CYCLES)));

  assert_settle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SEQ_SETTLE) && (settle_len == 16'(SETTLE_CYCLES - 1))) |=> (state == SEQ_CONVERT));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !result_load |=> $stable(result));

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DONE) |=> stat);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == ADDR_IRQST) && clr_bit && (state != SEQ_DONE)) |=> !stat);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(stat) || $rose(ie)));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == ADDR_CTRL) && (state != SEQ_IDLE)) |=> $stable(ctrl));

endmodule

bind adc_seq_ctrl adc_seq_checker #(
  .DATA_W        (DATA_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_addr   (host_addr),
  .clr_bit     (host_wdata[2]),
  .cnv_start   (cnv_start),
  .irq         (irq),
  .state       (seq_state),
  .stat        (done_stat),
  .ie          (irq_en),
  .ctrl        (ctrl_word),
  .result      (result_word),
  .result_load (res_load)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [1:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        cnv_start;
  logic [3:0]  mux_sel;
  logic        cnv_busy;
  logic [15:0] cnv_data;
  logic        irq;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cnv_start  (cnv_start),
    .mux_sel    (mux_sel),
    .cnv_busy   (cnv_busy),
    .cnv_data   (cnv_data),
    .irq        (irq)
  );

  // Converter model: busy for m_lat cycles after a start, data valid at busy fall
  int          m_lat = 4;
  logic [15:0] m_val = 16'h0;
  logic        m_busy;
  int          m_cnt;
  logic [15:0] m_data;
  assign cnv_busy = m_busy;
  assign cnv_data = m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= 0;
      m_data <= 16'h0;
    end else if (cnv_start && !m_busy) begin
      m_busy <= 1'b1;
      m_cnt  <= m_lat;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        m_busy <= 1'b0;
        m_data <= m_val;
      end
      m_cnt <= m_cnt - 1;
    end
  end

  int n_starts = 0;
  always @(posedge clk) if (rst_n && cnv_start) n_starts++;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 2'd2;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic bit exp_accept(input logic [15:0] w);
    int sel;
    sel = int'(w[4:1]);
    if (!w[0] || sel >= 10) return 1'b0;
    return w[5 + sel];
  endfunction

  function automatic int exp_cycles(input logic [15:0] w, input int lat);
    return 3 + lat + (w[15] ? 64 : 0);
  endfunction

  task automatic run_conv(input logic [15:0] w, input int lat, input logic [15:0] val);
    logic [15:0] rd;
    int s0;
    int k;
    int expk;
    m_lat = lat; m_val = val; s0 = n_starts;
    host_write(2'd0, w);
    host_read(2'd0, rd);
    check(rd == {w[15:1], 1'b0}, "R1", "control readback", rd, {w[15:1], 1'b0});
    check(mux_sel == w[4:1], "R1", "mux select", mux_sel, w[4:1]);
    if (exp_accept(w)) begin
      expk = exp_cycles(w, lat);
      k = 0;
      host_addr = 2'd2;
      while (k < 400) begin
        @(negedge clk);
        k++;
        if (host_rdata[2]) break;
      end
      check(k == expk, w[15] ? "R3" : "R2", "done latency", k, expk);
      check(n_starts == s0 + 1, "R2", "start pulse count", n_starts - s0, 1);
      host_read(2'd3, rd);
      check(rd == val, "R4", "result word", rd, val);
      host_write(2'd2, 16'h0004);
      host_read(2'd2, rd);
      check(rd == 16'h0, "R5", "status after clear", rd, 0);
    end else begin
      repeat (100) @(negedge clk);
      host_read(2'd2, rd);
      check(rd == 16'h0, "R7", "status after ignored start", rd, 0);
      check(n_starts == s0, "R7", "no start pulse", n_starts - s0, 0);
    end
  endtask

  localparam int WD_LIMIT = 150000;
  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run not finished, expected completion before %0d cycles", WD_LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] w1;
    int s0;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; host_wr = 1'b0; host_addr = 2'd0; host_wdata = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      host_read(2'(a), rd);
      check(rd == 16'h0, "R9", "register after reset", rd, 0);
    end
    check(irq == 1'b0, "R9", "irq after reset", irq, 0);
    check(cnv_start == 1'b0, "R9", "start after reset", cnv_start, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corner cases
    run_conv(16'h0021, 4, 16'h8000);                      // ch0, R2
    run_conv(16'h8000 | 16'h4000 | (9 << 1) | 1, 2, 16'h0000); // ch9 settled, R3
    run_conv(16'h2000 | (8 << 1) | 1, 1, 16'hFFFF);        // ch8, shortest busy
    run_conv(16'h0020 | (3 << 1) | 1, 3, 16'h1234);        // ch3 disabled, R7
    run_conv(16'h7FE0 | (12 << 1) | 1, 3, 16'h1234);       // select out of range, R7
    run_conv(16'h0040 | (1 << 1), 3, 16'h1234);            // start bit clear, R7

    // Interrupt gating and write-1-to-clear, R5 and R6
    m_lat = 3; m_val = 16'hA5A5;
    host_write(2'd1, 16'h0000);
    host_write(2'd0, 16'h0021);
    repeat (20) @(negedge clk);
    host_read(2'd2, rd);
    check(rd == 16'h0004, "R5", "status set on completion", rd, 4);
    check(irq == 1'b0, "R6", "irq masked", irq, 0);
    host_write(2'd1, 16'h0004);
    check(irq == 1'b1, "R6", "irq enabled", irq, 1);
    host_write(2'd2, 16'hFFFB);
    host_read(2'd2, rd);
    check(rd == 16'h0004, "R5", "write 0 keeps status", rd, 4);
    host_write(2'd2, 16'h0004);
    check(irq == 1'b0, "R6", "irq after clear", irq, 0);

    // Control write during a running conversion, R8
    m_lat = 3; m_val = 16'h0F0F; s0 = n_starts;
    w1 = 16'h8000 | 16'h0080 | (2 << 1) | 1;
    host_write(2'd0, w1);
    host_write(2'd0, 16'h7FE0 | (4 << 1) | 1);
    host_read(2'd0, rd);
    check(rd == {w1[15:1], 1'b0}, "R8", "control kept while busy", rd, {w1[15:1], 1'b0});
    check(mux_sel == 4'd2, "R8", "mux kept while busy", mux_sel, 2);
    repeat (90) @(negedge clk);
    check(n_starts == s0 + 1, "R8", "single start", n_starts - s0, 1);
    host_read(2'd3, rd);
    check(rd == 16'h0F0F, "R8", "first conversion result", rd, 16'h0F0F);
    host_write(2'd2, 16'h0004);

    // Constrained random conversions
    for (int i = 0; i < 30; i++) begin
      logic [15:0] w;
      w[0]     = 1'b1;
      w[4:1]   = 4'($urandom % 12);
      w[14:5]  = 10'($urandom);
      w[15]    = ($urandom % 4) == 0;
      run_conv(w, 1 + int'($urandom % 8), 16'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule